// File: doc/BRIEF.md
# SPI Firmware Download Master

This block is a serial-peripheral master that pushes a firmware image into the RAM of a slave device over a four-wire link. Upstream logic hands it 16-bit words on a ready/valid input. The engine sends each word in its own chip-select frame. Before the first clock edge of a frame it holds a programmable lead-in time, and after each frame it keeps chip-select high for a programmable guard gap. The serial clock idles low. MOSI changes on falling edges and MISO is sampled on rising edges, so the link runs in SPI mode 0.

The image length is given in words when a run starts. The words go out in chunks of a fixed byte size. After each full chunk the engine raises a chunk-done level and waits for a continue pulse. A short final chunk ends the run with a done pulse and no chunk wait. Each word clocked in from MISO is presented with a one-cycle valid strobe. An abort request lets the current word finish, waits out the guard gap and returns the engine to idle.

Top module: `spi_fw_loader`

## Requirements
- R1: Out of reset and whenever idle, chip-select is high, the serial clock is low, and busy, done, chunk_done, in_ready and rx_valid are all low.
- R2: The serial clock is low whenever chip-select is high. Each frame has exactly 16 rising edges, and each high phase lasts DIV/2 system clocks.
- R3: MOSI carries the accepted word most significant bit first. It is set before the first rising edge and does not change while the clock is high.
- R4: The first rising edge of a frame comes exactly LEAD_PERIODS*DIV + DIV/2 system clocks after chip-select falls.
- R5: Between two frames, chip-select stays high for at least GAP_PERIODS*DIV + 1 system clocks.
- R6: MISO is sampled on rising edges, MSB first. The received word appears on rx_data with rx_valid high for exactly one cycle, in the cycle after chip-select rises.
- R7: in_ready is high only while chip-select is high, between frames. Every accepted word is sent exactly once and in order, under any backpressure.
- R8: After each CHUNK_BYTES/2 words that are not the last words of the image, chunk_done stays high with chip-select high and no frame starts until cont is pulsed.
- R9: After the last word's guard gap, done pulses for one cycle and busy then falls. No chunk wait follows the final chunk. A start with length 0 gives done with no frame.
- R10: Holding start high while busy does not restart or lengthen the run.
- R11: abort lets the current word finish with all 16 clocks, keeps the guard gap, then returns to idle without a done pulse and starts no more frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; only looked at while idle |
| abort | input | 1 | Stop after the current word |
| cont | input | 1 | Release the engine after a chunk |
| len_words | input | LEN_W | Image length in 16-bit words, taken at start |
| busy | output | 1 | High from start until back in idle |
| done | output | 1 | One-cycle pulse at the end of a full run |
| chunk_done | output | 1 | High while waiting for cont |
| in_data | input | WORD_BITS | Next word to send |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Engine takes in_data this cycle if in_valid |
| rx_data | output | WORD_BITS | Last word received on MISO |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench attacks frame edges. It checks the exact lead-in count, which a divider that is off by half a period would miss, and it checks the guard gap on every frame boundary. If chip-select were held across words, the bench would count 32 rising edges in one frame. Image lengths of 0, 1, one full chunk, a multiple of the chunk size and a partial final chunk test the chunk accounting. An engine that waits for cont after its last chunk, or that never raises done, would hang or report a wrong chunk count. Bursty input with delays of varying length would expose a word that is lost or sent twice. An abort in the middle of a word would show up as a truncated frame or an extra done pulse.

// File: rtl/spiboot_pkg.sv
package spiboot_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LEAD,
      ST_SHIFT,
      ST_GAP,
      ST_HOLD,
      ST_DONE
   } spiboot_state_e;
endpackage

// File: rtl/spiboot_pacer.sv
module spiboot_pacer #(
   parameter int DIV   = 100,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             sclk,
   output logic             rise_ev,
   output logic             fall_ev
);
   localparam int HALF = DIV / 2;
   localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] FALL_AT = CNT_W'(DIV - 1);

   assign rise_ev = run && (cnt == RISE_AT);
   assign fall_ev = run && (cnt == FALL_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else begin
         cnt <= clr ? '0 : cnt + CNT_W'(1);
         if (!run)         sclk <= 1'b0;
         else if (rise_ev) sclk <= 1'b1;
         else if (fall_ev) sclk <= 1'b0;
      end
   end

   // R2: a rising event only from a low clock, a falling event only from a high one
   assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev |-> !sclk);
   assert_fall_from_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev |-> sclk);
endmodule

// File: rtl/spiboot_shifter.sv
module spiboot_shifter #(
   parameter int WORD_BITS   = 16,
   parameter int SYNC_STAGES = 1,
   parameter int BIT_W       = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [WORD_BITS-1:0] load_word,
   input  logic                 rise_ev,
   input  logic                 fall_ev,
   input  logic                 miso_pin,
   output logic                 mosi_bit,
   output logic                 last_bit,
   output logic [WORD_BITS-1:0] rx_word,
   output logic                 rx_strobe
);
   logic                 miso_s;
   logic [WORD_BITS-1:0] tx_sh;
   logic [WORD_BITS-1:0] rx_sh;
   logic [BIT_W-1:0]     bitcnt;
   logic                 fin;
   logic                 fin_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign miso_s = miso_pin;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= miso_pin;
         end
         assign miso_s = stage_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], miso_pin};
         end
         assign miso_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign last_bit = (bitcnt == BIT_W'(WORD_BITS - 1));
   assign fin      = fall_ev && last_bit;
   assign mosi_bit = tx_sh[WORD_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh     <= '0;
         rx_sh     <= '0;
         bitcnt    <= '0;
         rx_word   <= '0;
         fin_q     <= 1'b0;
         rx_strobe <= 1'b0;
      end else begin
         if (load) begin
            tx_sh  <= load_word;
            bitcnt <= '0;
         end else if (fall_ev) begin
            tx_sh  <= tx_sh << 1;
            bitcnt <= bitcnt + BIT_W'(1);
         end
         if (rise_ev) rx_sh <= {rx_sh[WORD_BITS-2:0], miso_s};
         if (fin) rx_word <= rx_sh;
         fin_q     <= fin;
         rx_strobe <= fin_q;
      end
   end

   // R2: no falling event may run the bit counter past the word length
   assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev |-> (bitcnt <= BIT_W'(WORD_BITS - 1)));
endmodule

// File: rtl/spiboot_chunker.sv
module spiboot_chunker #(
   parameter int LEN_W       = 16,
   parameter int CHUNK_WORDS = 116
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             word_fin,
   input  logic             cont,
   output logic             left_zero,
   output logic             chunk_full
);
   localparam int CW = $clog2(CHUNK_WORDS + 1);

   logic [LEN_W-1:0] left;
   logic [CW-1:0]    in_chunk;

   assign left_zero  = (left == '0);
   assign chunk_full = (in_chunk == CW'(CHUNK_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left     <= '0;
         in_chunk <= '0;
      end else if (load) begin
         left     <= len;
         in_chunk <= '0;
      end else begin
         if (word_fin && !left_zero) left <= left - LEN_W'(1);
         if (cont)          in_chunk <= '0;
         else if (word_fin) in_chunk <= in_chunk + CW'(1);
      end
   end

   // R8: the word count inside a chunk never passes the chunk size
   assert_chunk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_chunk <= CW'(CHUNK_WORDS));
endmodule

// File: rtl/spi_fw_loader.sv
module spi_fw_loader
   import spiboot_pkg::*;
#(
   parameter int DIV          = 100,
   parameter int LEAD_PERIODS = 2,
   parameter int GAP_PERIODS  = 2,
   parameter int CHUNK_BYTES  = 232,
   parameter int LEN_W        = 16,
   parameter int WORD_BITS    = 16,
   parameter int SYNC_STAGES  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 abort,
   input  logic                 cont,
   input  logic [LEN_W-1:0]     len_words,
   output logic                 busy,
   output logic                 done,
   output logic                 chunk_done,
   input  logic [WORD_BITS-1:0] in_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   output logic [WORD_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 sclk,
   output logic                 cs_n,
   output logic                 mosi,
   input  logic                 miso
);
   localparam int CHUNK_WORDS = CHUNK_BYTES / 2;
   localparam int MAX_GUARD   = (LEAD_PERIODS > GAP_PERIODS) ? LEAD_PERIODS : GAP_PERIODS;
   localparam int CNT_W       = $clog2(MAX_GUARD * DIV + 1);
   localparam int BIT_W       = $clog2(WORD_BITS + 1);
   localparam logic [CNT_W-1:0] LEAD_END = CNT_W'(LEAD_PERIODS * DIV - 1);
   localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_PERIODS * DIV - 1);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be even and at least 2");
      end
      if (LEAD_PERIODS < 2 || GAP_PERIODS < 2) begin : g_bad_guard
         $error("guard periods must be at least 2");
      end
      if (CHUNK_BYTES < 2 || (CHUNK_BYTES % 2) != 0) begin : g_bad_chunk
         $error("CHUNK_BYTES must be even and at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= DIV / 2) begin : g_bad_sync
         $error("SYNC_STAGES must be below DIV/2");
      end
      if (WORD_BITS < 2) begin : g_bad_word
         $error("WORD_BITS must be at least 2");
      end
   endgenerate

   spiboot_state_e   st, st_nx;
   logic [CNT_W-1:0] cnt;
   logic             clr, run, rise_ev, fall_ev;
   logic             last_bit, mosi_bit, word_fin;
   logic             left_zero, chunk_full;
   logic             abort_pend, load_word, chunk_load, chunk_cont;

   assign run        = (st == ST_SHIFT);
   assign word_fin   = fall_ev && last_bit;
   assign load_word  = (st == ST_FETCH) && in_valid && !abort;
   assign chunk_load = (st == ST_IDLE) && start;
   assign chunk_cont = (st == ST_HOLD) && cont && !abort;
   assign clr        = (st_nx != st) || fall_ev;

   assign busy       = (st != ST_IDLE);
   assign done       = (st == ST_DONE);
   assign chunk_done = (st == ST_HOLD);
   assign in_ready   = (st == ST_FETCH);
   assign mosi       = !cs_n && mosi_bit;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (start) st_nx = (len_words == '0) ? ST_DONE : ST_FETCH;
         ST_FETCH: begin
            if (abort)         st_nx = ST_IDLE;
            else if (in_valid) st_nx = ST_LEAD;
         end
         ST_LEAD:  if (cnt == LEAD_END) st_nx = ST_SHIFT;
         ST_SHIFT: if (word_fin) st_nx = ST_GAP;
         ST_GAP: begin
            if (cnt == GAP_END) begin
               if (abort_pend || abort) st_nx = ST_IDLE;
               else if (left_zero)      st_nx = ST_DONE;
               else if (chunk_full)     st_nx = ST_HOLD;
               else                     st_nx = ST_FETCH;
            end
         end
         ST_HOLD: begin
            if (abort)     st_nx = ST_IDLE;
            else if (cont) st_nx = ST_FETCH;
         end
         ST_DONE:  st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cs_n       <= 1'b1;
         abort_pend <= 1'b0;
      end else begin
         st   <= st_nx;
         cs_n <= !((st_nx == ST_LEAD) || (st_nx == ST_SHIFT));
         if (st == ST_IDLE)
            abort_pend <= 1'b0;
         else if (abort && (st == ST_LEAD || st == ST_SHIFT || st == ST_GAP))
            abort_pend <= 1'b1;
      end
   end

   spiboot_pacer #(.DIV(DIV), .CNT_W(CNT_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
      .cnt(cnt), .sclk(sclk), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   spiboot_shifter #(.WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES), .BIT_W(BIT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load_word), .load_word(in_data),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .miso_pin(miso),
      .mosi_bit(mosi_bit), .last_bit(last_bit), .rx_word(rx_data), .rx_strobe(rx_valid)
   );

   spiboot_chunker #(.LEN_W(LEN_W), .CHUNK_WORDS(CHUNK_WORDS)) u_chunk (
      .clk(clk), .rst_n(rst_n), .load(chunk_load), .len(len_words),
      .word_fin(word_fin), .cont(chunk_cont),
      .left_zero(left_zero), .chunk_full(chunk_full)
   );

   assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);
   assert_clock_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   assert_rx_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   assert_ready_in_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> cs_n);
   assert_chunk_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_done && !cont && !abort) |=> (chunk_done && cs_n));
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   assert_abort_leaves_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && in_ready) |=> !busy);
endmodule

// File: tb/spi_fw_loader_test.sv
`timescale 1ns/1ps
module spi_fw_loader_test;
   localparam int DIV = 4;
   localparam int LEAD = 2;
   localparam int GAP = 3;
   localparam int CHB = 6;
   localparam int LW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, abort = 1'b0, cont = 1'b0;
   logic [LW-1:0] len_words = '0;
   logic busy, done, chunk_done, in_ready, rx_valid, sclk, cs_n, mosi;
   logic [15:0] in_data = '0;
   logic in_valid = 1'b0;
   logic [15:0] rx_data;
   logic miso = 1'b0;

   always #2 clk = ~clk;

   spi_fw_loader #(.DIV(DIV), .LEAD_PERIODS(LEAD), .GAP_PERIODS(GAP), .CHUNK_BYTES(CHB),
                   .LEN_W(LW), .WORD_BITS(16), .SYNC_STAGES(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cont(cont),
      .len_words(len_words), .busy(busy), .done(done), .chunk_done(chunk_done),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
      .mosi(mosi), .miso(miso));

   function automatic logic [15:0] fword(int k);
      return 16'((k * 40503 + 1057) & 16'hFFFF);
   endfunction
   function automatic logic [15:0] gword(int k);
      return 16'(((k * 4919) ^ 42435) & 16'hFFFF);
   endfunction

   int t_checks = 0, t_fails = 0, m_checks = 0, m_fails = 0;

   task automatic chk_t(input bit ok, input string req, input int act, input int exp);
      t_checks++;
      if (!ok) begin
         t_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask
   task automatic chk_m(input bit ok, input string req, input int act, input int exp);
      m_checks++;
      if (!ok) begin
         m_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // producer with optional backpressure
   int bp_mode = 0, feed_len = 0, sidx = 0, dly = 0;
   bit hs = 0;
   logic pbusy_p = 1'b0;
   always @(negedge clk) begin
      if (!rst_n) begin
         in_valid = 1'b0; sidx = 0; hs = 0; dly = 0;
      end else begin
         if (busy && !pbusy_p) begin
            sidx = 0; hs = 0; dly = 0; in_valid = 1'b0;
         end
         if (hs) begin
            sidx++; hs = 0; in_valid = 1'b0;
            dly = (bp_mode != 0) ? (sidx % 4) * 3 : 0;
         end
         if (!in_valid && sidx < feed_len) begin
            if (dly > 0) dly--;
            else begin
               in_valid = 1'b1;
               in_data  = fword(sidx);
            end
         end
         hs = in_valid && in_ready;
      end
      pbusy_p = busy;
   end

   // pin monitor and slave model
   int cyc = 0, fr = 0, rx_idx = 0, done_seen = 0, rises = 0;
   int fall_cyc = 0, hi_cyc = 0, csr_cyc = 0, sbit = 0;
   bit have_prev = 0;
   logic pcs = 1'b1, psclk = 1'b0, pbusy = 1'b0;
   logic [15:0] mword = '0, sl = '0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (busy && !pbusy) begin
            fr = 0; rx_idx = 0; done_seen = 0; have_prev = 0;
         end
         if (pcs && !cs_n) begin
            if (have_prev) chk_m(cyc - csr_cyc >= GAP*DIV + 1, "R5 guard gap", cyc - csr_cyc, GAP*DIV + 1);
            fall_cyc = cyc; rises = 0; mword = '0;
            sl = gword(fr); sbit = 15; miso = sl[15];
         end
         if (!cs_n && !psclk && sclk) begin
            rises++;
            mword = {mword[14:0], mosi};
            if (rises == 1) chk_m(cyc - fall_cyc == LEAD*DIV + DIV/2, "R4 lead-in", cyc - fall_cyc, LEAD*DIV + DIV/2);
            hi_cyc = cyc;
         end
         if (psclk && !sclk) begin
            chk_m(cyc - hi_cyc == DIV/2, "R2 high phase", cyc - hi_cyc, DIV/2);
            if (!cs_n && sbit > 0) begin
               sbit--; miso = sl[sbit];
            end
         end
         if (!pcs && cs_n) begin
            chk_m(rises == 16, "R2 edges per frame", rises, 16);
            chk_m(mword == fword(fr), "R3 mosi word", int'(mword), int'(fword(fr)));
            fr++; csr_cyc = cyc; have_prev = 1;
         end
         if (rx_valid) begin
            chk_m(cyc == csr_cyc + 1, "R6 strobe timing", cyc, csr_cyc + 1);
            chk_m(rx_data == gword(rx_idx), "R6 miso word", int'(rx_data), int'(gword(rx_idx)));
            rx_idx++;
         end
         if (sclk && cs_n) chk_m(0, "R2 clock while deselected", 1, 0);
         if (in_ready && !cs_n) chk_m(0, "R7 ready inside frame", 1, 0);
         if (done) done_seen++;
      end
      pcs = cs_n; psclk = sclk; pbusy = busy;
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic run_image(input int len, input int bp, input int exp_chunks, input bit hold);
      int chunks = 0, guard = 0, frz = 0;
      bit seen_done = 0;
      bp_mode = bp; feed_len = len; len_words = LW'(len);
      start = 1'b1;
      tick();
      if (!hold) start = 1'b0;
      while (!seen_done && guard < 20000) begin
         if (hold && fr >= 2) start = 1'b0;
         if (chunk_done) begin
            chunks++; frz = fr;
            chk_t(cs_n == 1'b1, "R8 deselected during chunk wait", int'(cs_n), 1);
            repeat (20) tick();
            chk_t(chunk_done && fr == frz, "R8 no frame before cont", fr, frz);
            cont = 1'b1;
            tick();
            cont = 1'b0;
         end
         if (done) seen_done = 1;
         else begin
            tick(); guard++;
         end
      end
      start = 1'b0;
      chk_t(seen_done, "R9 done reached", int'(seen_done), 1);
      chk_t(fr == len, "R7 frames sent", fr, len);
      chk_t(chunks == exp_chunks, "R8 chunk waits", chunks, exp_chunks);
      chk_t(rx_idx == len, "R6 words received", rx_idx, len);
      if (hold) chk_t(fr == len, "R10 start held while busy", fr, len);
      tick();
      chk_t(!done && !busy, "R9 single done pulse then idle", int'(done) + int'(busy), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #1;
      chk_t(cs_n && !sclk, "R1 pins after reset", int'(cs_n), 1);
      chk_t(!busy && !done && !chunk_done, "R1 control after reset", int'(busy) + int'(done) + int'(chunk_done), 0);
      chk_t(!in_ready && !rx_valid, "R1 strobes after reset", int'(in_ready) + int'(rx_valid), 0);
      rst_n = 1'b1;
      tick();
      chk_t(cs_n && !busy, "R1 idle after release", int'(busy), 0);

      run_image(7, 0, 2, 0);   // partial final chunk
      run_image(6, 1, 1, 0);   // exact multiple with backpressure
      run_image(3, 1, 0, 0);   // exactly one chunk
      run_image(1, 0, 0, 0);
      run_image(0, 0, 0, 0);   // empty image
      run_image(4, 0, 1, 1);   // start held high

      // R11 abort in the middle of the second word
      begin
         int guard = 0;
         bp_mode = 0; feed_len = 5; len_words = LW'(5);
         start = 1'b1;
         tick();
         start = 1'b0;
         while (!(fr == 1 && rises >= 3 && !cs_n) && guard < 5000) begin
            tick(); guard++;
         end
         abort = 1'b1;
         tick();
         abort = 1'b0;
         guard = 0;
         while (busy && guard < 5000) begin
            tick(); guard++;
         end
         chk_t(fr == 2, "R11 current word completed", fr, 2);
         chk_t(rx_idx == 2, "R11 received word delivered", rx_idx, 2);
         chk_t(done_seen == 0, "R11 no done on abort", done_seen, 0);
         repeat (60) tick();
         chk_t(fr == 2 && cs_n && !busy, "R11 stays idle", fr, 2);
      end

      run_image(2, 0, 0, 0);   // recovery after abort

      $display("End of test - %0d assertions evaluated, %0d failures",
               t_checks + m_checks, t_fails + m_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures",
               t_checks + m_checks + 1, t_fails + m_fails + 1);
      $finish;
   end
endmodule